// File: doc/BRIEF.md
# I2C Channel-Select Control Target

This block is a bus target on a two-wire serial bus that owns a single 8-bit channel-select register. Each bit of that register drives one channel-enable output, so that any subset of eight downstream bus segments can be connected at once. A bus master writes a selection byte and can read the current selection back. The block takes oversampled SCL and SDA lines, a system clock, an active-low reset and three address-select pins. It drives an open-drain pull-down for SDA and the eight enable lines.

A written selection is never applied while the transfer is still running. Bytes go into a pending holding register, and the enable outputs change only when the master ends the transfer with STOP. Every SCL and SDA line is therefore idle-high at the moment a channel connects. A repeated START abandons a pending byte. The analog pass switches, level translation and clock stretching are handled elsewhere.

Top module: `i2c_chsel_target`

## Requirements
- R1: The 7-bit target address is binary 1110 in the upper four bits and `addr_sel[2:0]` in the lower three. When an address byte matches (bit 0 of that byte is read = 1 / write = 0), the block pulls SDA low during the ninth SCL clock. The pull-down only rises while SCL is low.
- R2: On a mismatched address the block does not acknowledge, ignores every bit that follows, and keeps SDA released until the next START. A STOP closing such a transfer leaves `ch_en_o` unchanged.
- R3: In a write transfer, each data byte after the acknowledged address is acknowledged and is taken as a selection. Bit n of the byte (first bit on the wire = bit 7) maps to `ch_en_o[n]`, 1 = enabled, and any combination is allowed.
- R4: `ch_en_o` changes only in response to a STOP condition or reset, never during a transfer.
- R5: When a write carries several data bytes, the last one received is the value applied at STOP.
- R6: In a read transfer the block shifts out the applied `ch_en_o` value, most significant bit first, with each bit driven after an SCL falling edge.
- R7: During a read, an ACK (SDA low) from the master in the ninth clock makes the block send the register value again. A NACK (SDA high) ends the read with SDA released.
- R8: A repeated START before STOP discards any pending byte, and `ch_en_o` keeps its previous value through the following transfer.
- R9: With `rst_n` low at a clock edge, the register and the pending byte clear synchronously. `ch_en_o` reads 0x00 and SDA is released, whatever the bus is doing.
- R10: SCL and SDA pass through a two-flop synchroniser. START is SDA falling while SCL is high, STOP is SDA rising while SCL is high, and received bits are sampled on the SCL rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND level) |
| addr_sel | input | 3 | Low three bits of the target address |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain enable) |
| ch_en_o | output | 8 | Applied channel enables, bit n = channel n |

## Verification
The hardest case to reach from the ports is a pending byte that is still held when something other than a clean STOP ends the transfer. This covers a repeated START directly after a data acknowledge, and also a reset asserted halfway through a write. The bench drives a bit-accurate master that can stop after any acknowledge, insert a repeated START there, or pull reset while a selection is pending. A per-clock reference model tracks the pending and applied values from the master's own view of the bus. Any premature or missing enable change therefore shows up on the exact clock where it happens.

// File: rtl/i2c_chsel_pkg.sv
// Package: shared types for the channel-select target.
// Assumes: a single transfer engine owns the state encoding below.
package i2c_chsel_pkg;

    // Transfer phases of the bus target.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_RD_NEXT
    } xfer_st_e;

endpackage

// File: rtl/i2c_bus_sync.sv
// Module: i2c_bus_sync
// Brings SCL and SDA into the clock domain through STAGES flops, keeps one
// extra history flop and decodes START, STOP and SCL edges from it.
// Assumes: the clock is at least several times faster than SCL; idle bus is high.
module i2c_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    // Synchroniser chain plus one history flop, reset to the idle-high level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    // Bus condition decode from the synchronised level and its history.
    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/i2c_xfer_engine.sv
// Module: i2c_xfer_engine
// Bit-level transfer state machine: address match and acknowledge, write
// byte capture with acknowledge, read byte shift-out and master ACK handling.
// Assumes: ADDR_W == NUM_CH - 1 (address plus direction fill one byte);
// START/STOP override every phase.
module i2c_xfer_engine
    import i2c_chsel_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [NUM_CH-1:0] rd_value,
    output logic              sda_pull_o,
    output logic              wr_stb,
    output logic [NUM_CH-1:0] wr_data
);
    localparam int              CNT_W = $clog2(NUM_CH);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_CH - 1);

    xfer_st_e          st;
    logic [CNT_W-1:0]  bit_cnt;
    logic [NUM_CH-2:0] rx_sh;
    logic [NUM_CH-2:0] tx_sh;
    logic              rd_mode;
    logic              ack_phase;

    // Write strobe on the eighth sampled bit of a data byte.
    always_comb begin
        wr_stb  = (st == ST_WR_DATA) && scl_rise && (bit_cnt == LAST)
                  && !start_det && !stop_det;
        wr_data = {rx_sh, sda_s};
    end

    // Transfer phase sequencing and SDA pull-down control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            bit_cnt    <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            rd_mode    <= 1'b0;
            ack_phase  <= 1'b0;
            sda_pull_o <= 1'b0;
        end else if (start_det) begin
            st         <= ST_ADDR;
            bit_cnt    <= '0;
            ack_phase  <= 1'b0;
            sda_pull_o <= 1'b0;
        end else if (stop_det) begin
            st         <= ST_IDLE;
            ack_phase  <= 1'b0;
            sda_pull_o <= 1'b0;
        end else begin
            unique case (st)
                ST_ADDR: begin
                    if (scl_rise) begin
                        rx_sh   <= {rx_sh[NUM_CH-3:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == LAST) begin
                            bit_cnt <= '0;
                            rd_mode <= sda_s;
                            st      <= (rx_sh == own_addr) ? ST_ADDR_ACK : ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK, ST_WR_ACK: begin
                    if (scl_fall) begin
                        if (!ack_phase) begin
                            ack_phase  <= 1'b1;
                            sda_pull_o <= 1'b1;
                        end else begin
                            ack_phase <= 1'b0;
                            bit_cnt   <= '0;
                            if (st == ST_ADDR_ACK && rd_mode) begin
                                st         <= ST_RD_DATA;
                                tx_sh      <= rd_value[NUM_CH-2:0];
                                sda_pull_o <= ~rd_value[NUM_CH-1];
                            end else begin
                                st         <= ST_WR_DATA;
                                sda_pull_o <= 1'b0;
                            end
                        end
                    end
                end
                ST_WR_DATA: begin
                    if (scl_rise) begin
                        rx_sh   <= {rx_sh[NUM_CH-3:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == LAST) begin
                            bit_cnt <= '0;
                            st      <= ST_WR_ACK;
                        end
                    end
                end
                ST_RD_DATA: begin
                    if (scl_fall) begin
                        if (bit_cnt == LAST) begin
                            bit_cnt    <= '0;
                            sda_pull_o <= 1'b0;
                            st         <= ST_RD_ACK;
                        end else begin
                            bit_cnt    <= bit_cnt + 1'b1;
                            tx_sh      <= {tx_sh[NUM_CH-3:0], 1'b0};
                            sda_pull_o <= ~tx_sh[NUM_CH-2];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) st <= sda_s ? ST_IDLE : ST_RD_NEXT;
                end
                ST_RD_NEXT: begin
                    if (scl_fall) begin
                        st         <= ST_RD_DATA;
                        bit_cnt    <= '0;
                        tx_sh      <= rd_value[NUM_CH-2:0];
                        sda_pull_o <= ~rd_value[NUM_CH-1];
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sda_pull_o);  // R2
    AST_WRITE_ONLY_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !rd_mode);  // R3
endmodule

// File: rtl/chsel_reg.sv
// Module: chsel_reg
// Holds the pending selection and the applied channel enables. A pending
// byte is applied at STOP and dropped at START.
// Assumes: write strobe, discard and apply are never active together.
module chsel_reg #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [NUM_CH-1:0] wr_data,
    input  logic              discard,
    input  logic              apply,
    output logic [NUM_CH-1:0] ch_en,
    output logic              pend_valid
);
    logic [NUM_CH-1:0] pend;

    // Pending capture, discard on START, transfer to the enables on STOP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend       <= '0;
            pend_valid <= 1'b0;
            ch_en      <= '0;
        end else if (wr_stb) begin
            pend       <= wr_data;
            pend_valid <= 1'b1;
        end else if (discard) begin
            pend_valid <= 1'b0;
        end else if (apply) begin
            if (pend_valid) ch_en <= pend;
            pend_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_chsel_target.sv
// Module: i2c_chsel_target
// Bus target with one channel-select register: writes are held pending and
// applied to the enable outputs at STOP; reads return the applied value.
// Assumes: SCL/SDA are oversampled by clk; SDA is open-drain outside.
module i2c_chsel_target #(
    parameter int             NUM_CH      = 8,
    parameter int             SEL_W       = 3,
    parameter int             SYNC_STAGES = 2,
    parameter logic [3:0]     ADDR_HI     = 4'b1110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [SEL_W-1:0]  addr_sel,
    output logic              sda_pull_o,
    output logic [NUM_CH-1:0] ch_en_o
);
    localparam int ADDR_W = $bits(ADDR_HI) + SEL_W;

    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_stb, pend_valid;
    logic [NUM_CH-1:0] wr_data;
    logic [ADDR_W-1:0] own_addr;

    assign own_addr = {ADDR_HI, addr_sel};

    i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_xfer_engine #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det),
        .own_addr(own_addr), .rd_value(ch_en_o), .sda_pull_o(sda_pull_o),
        .wr_stb(wr_stb), .wr_data(wr_data)
    );

    chsel_reg #(.NUM_CH(NUM_CH)) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
        .discard(start_det), .apply(stop_det), .ch_en(ch_en_o),
        .pend_valid(pend_valid)
    );

    AST_EN_HOLD_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_det |=> $stable(ch_en_o));  // R4
    AST_START_DROPS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (!pend_valid && $stable(ch_en_o)));  // R8
    AST_PULL_RISES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_s);  // R1
    AST_STOP_NO_PENDING_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !pend_valid) |=> $stable(ch_en_o));  // R2
endmodule

// File: tb/i2c_chsel_target_tb.sv
module i2c_chsel_target_tb;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam int WATCHDOG   = 150000;
    localparam logic [6:0] MY_ADDR = 7'b1110101;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] addr_sel = 3'b101;
    logic       sda_pull;
    logic [7:0] ch_en;
    logic       sda_line;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    // Reference model state
    logic [7:0] exp_en = 8'h00;
    logic [7:0] m_pend = 8'h00;
    bit         m_pend_valid = 1'b0;
    logic [1:0] b1 = 2'b11, b2 = 2'b11, b3 = 2'b11;

    assign sda_line = sda_m & ~sda_pull;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_chsel_target u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .addr_sel(addr_sel), .sda_pull_o(sda_pull), .ch_en_o(ch_en)
    );

    // Model: the bus as seen two clocks late; STOP applies, START discards (R4, R8, R9, R10).
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_en       <= 8'h00;
            m_pend_valid <= 1'b0;
            b1 <= 2'b11; b2 <= 2'b11; b3 <= 2'b11;
        end else begin
            b1 <= {scl_m, sda_line};
            b2 <= b1;
            b3 <= b2;
            if (b2[1] && b3[1] && b3[0] && !b2[0]) m_pend_valid <= 1'b0;
            if (b2[1] && b3[1] && !b3[0] && b2[0]) begin
                if (m_pend_valid) exp_en <= m_pend;
                m_pend_valid <= 1'b0;
            end
        end
    end

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", req, act, expv, cyc);
        end
    endtask

    // Per-clock comparison of the enables against the model (R4, R5, R9).
    always @(negedge clk) begin
        cyc++;
        if (rst_n && !done) check("R4 enables vs model", ch_en, exp_en);
        if (cyc > WATCHDOG && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual %0d expected <= %0d cycles", cyc, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q/2);
        acked = !sda_line;
        tick(Q/2);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic read_byte(input logic master_ack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; tick(Q);
            scl_m = 1'b1; tick(Q/2);
            v[i] = sda_line;
            tick(Q/2);
            scl_m = 1'b0; tick(Q);
        end
        send_bit(!master_ack);
    endtask

    // Full write transfer; the model records each byte the target acknowledges.
    task automatic write_bytes(input logic [7:0] d0, input logic [7:0] d1,
                               input logic [7:0] d2, input int n, input string req);
        logic ak;
        logic [7:0] data [3];
        data[0] = d0; data[1] = d1; data[2] = d2;
        bus_start;
        send_byte({MY_ADDR, 1'b0}, ak);
        check("R1 address ack on write", ak, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(data[i], ak);
            check(req, ak, 1);
            m_pend = data[i];
            m_pend_valid = 1'b1;
        end
    endtask

    initial begin
        logic ak;
        logic [7:0] rv;

        tick(4);
        check("R9 reset enables", ch_en, 0);
        check("R9 reset sda released", sda_pull, 0);
        rst_n = 1'b1;
        tick(4);

        // R3: single byte, several channels at once; R4 applied only after STOP.
        write_bytes(8'hA5, 8'h00, 8'h00, 1, "R3 data byte ack");
        check("R4 no change before STOP", ch_en, 0);
        bus_stop; tick(4);
        check("R3 enables after STOP", ch_en, 8'hA5);

        // R6, R7: read with ACK then NACK returns the value twice, MSB first.
        bus_start;
        send_byte({MY_ADDR, 1'b1}, ak);
        check("R1 address ack on read", ak, 1);
        read_byte(1'b1, rv);
        check("R6 read value", rv, 8'hA5);
        read_byte(1'b0, rv);
        check("R7 resend after ACK", rv, 8'hA5);
        check("R7 sda released after NACK", sda_pull, 0);
        bus_stop; tick(4);
        check("R6 read leaves enables", ch_en, 8'hA5);

        // R5: three bytes, last one wins.
        write_bytes(8'h01, 8'h80, 8'h3C, 3, "R5 each byte ack");
        bus_stop; tick(4);
        check("R5 last byte applied", ch_en, 8'h3C);

        // R2: mismatched address, no ack, following byte ignored.
        bus_start;
        send_byte({7'b1110100, 1'b0}, ak);
        check("R2 no ack on mismatch", ak, 0);
        send_byte(8'hFF, ak);
        check("R2 data ignored, no ack", ak, 0);
        check("R2 sda released", sda_pull, 0);
        bus_stop; tick(4);
        check("R2 enables unchanged", ch_en, 8'h3C);

        // R8: repeated START drops pending byte; read shows the old value.
        write_bytes(8'hF0, 8'h00, 8'h00, 1, "R8 data ack before restart");
        bus_start;
        send_byte({MY_ADDR, 1'b1}, ak);
        check("R8 restart address ack", ak, 1);
        read_byte(1'b0, rv);
        check("R8 read after restart", rv, 8'h3C);
        bus_stop; tick(4);
        check("R8 enables kept", ch_en, 8'h3C);

        // R3: all channels, then none.
        write_bytes(8'hFF, 8'h00, 8'h00, 1, "R3 all-on ack");
        bus_stop; tick(4);
        check("R3 all channels", ch_en, 8'hFF);
        write_bytes(8'h00, 8'h00, 8'h00, 1, "R3 all-off ack");
        bus_stop; tick(4);
        check("R3 no channels", ch_en, 8'h00);

        // R9: reset mid-write clears applied and pending values.
        write_bytes(8'h0F, 8'h00, 8'h00, 1, "R9 setup ack");
        bus_stop; tick(4);
        write_bytes(8'hF0, 8'h00, 8'h00, 1, "R9 pending ack");
        rst_n = 1'b0; tick(2);
        check("R9 mid-transfer reset", ch_en, 0);
        check("R9 sda released in reset", sda_pull, 0);
        rst_n = 1'b1; tick(2);
        bus_stop; tick(4);
        check("R9 pending dropped by reset", ch_en, 0);

        // R10: a bit changing only while SCL is low gives a clean address match.
        write_bytes(8'h42, 8'h00, 8'h00, 1, "R10 ack");
        bus_stop; tick(4);
        check("R10 sampled on SCL rise", ch_en, 8'h42);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule